// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave with Cascade Select

This block is the digital half of a two-wire serial memory that holds 2048 bytes. A bus master drives the clock line and shares an open-drain data line with it. The block watches both lines, picks out START and STOP conditions, and decodes a slave byte. If the byte matches this device, the block moves bytes between the bus and an on-chip byte array. Three strap inputs give the device a select code, so up to eight of these slaves can share one bus. A write-protect input blocks stores into the array.

Both bus lines are sampled with a fast system clock. They pass through a synchronizer before any edge or condition is detected. The data line is modelled as an input, which is the wired-AND of the bus, plus an output that enables a pull-low driver.

A write transaction sets an 11-bit address and then stores data bytes one after another. The slave byte supplies the upper three address bits and the byte that follows supplies the lower eight. A read transaction returns bytes starting at the internal address. That address is left by the last access, so the master can send a write with an address and no data, then a repeated START and a read, to read from any address.

Top module: `twi_eeprom_slave`

## Requirements
- R1: After reset the pull-low enable is 0. Bytes clocked on the bus before any START get no acknowledge.
- R2: A START (SDA falling while SCL is high) begins decoding of a new slave byte, even in the middle of a transaction and without a STOP. A STOP (SDA rising while SCL is high) returns the slave to idle. After a STOP the slave drives nothing until the next START.
- R3: The pull-low enable changes only while SCL is low. Incoming bits are taken at the rising edge of SCL, most significant bit first.
- R4: A slave byte matches only if bit 7 is 1, bit 6 equals strap[2], bit 5 equals the inverse of strap[1] and bit 4 equals strap[0]. On a mismatch the slave gives no acknowledge and drives nothing until the next START.
- R5: The slave acknowledges, by pulling SDA low in the ninth clock, a matching slave byte, the address byte of a write, and every data byte of a write.
- R6: Bit 0 of the slave byte selects the direction: 0 means write, 1 means read. In a write slave byte, bits 3..1 give address bits 10..8, and the next byte gives address bits 7..0.
- R7: Each write data byte is stored at the current address. The address then increments and wraps from 2047 to 0.
- R8: In a read, the slave sends the byte at the current address, most significant bit first, and then increments the address. It sends the next byte after the master acknowledges. After the master gives no acknowledge, it releases SDA and stays silent.
- R9: A read that has no address phase starts at the internal address left by the previous access.
- R10: While the write-protect input is high, data bytes are still acknowledged but the array contents do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line from the master |
| sda_i | input | 1 | Sensed level of the shared data line |
| sda_oe_o | output | 1 | When 1, the data line is pulled low |
| strap_i | input | 3 | Device select straps {A2, A1, A0} |
| wp_i | input | 1 | Write protect, active high |

## Verification
Most wrong internal states show up at the pull-low output within one byte time. A slip in the bit counter moves the acknowledge out of the ninth clock. A wrong select decode either acknowledges a foreign slave byte or misses its own. An address that is off by one, does not wrap, or loses the slave-byte upper bits shows up only on the next read, as a wrong data byte. The random write-then-read rounds exist to catch that case. The write-protect case is likewise only visible on a later read of the same address.

// File: rtl/twi_ee_pkg.sv
`timescale 1ns/1ps
package twi_ee_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK
  } ee_state_e;

  typedef enum logic [1:0] {
    K_DEV,
    K_ADDR,
    K_DATA
  } rx_kind_e;

  // Select decode: fixed one, two straps as-is, middle strap inverted.
  function automatic logic slave_match(input logic [7:0] b, input logic [2:0] strap);
    return b[7] & (b[6] == strap[2]) & (b[5] == ~strap[1]) & (b[4] == strap[0]);
  endfunction

endpackage

// File: rtl/twi_ee_frontend.sv
`timescale 1ns/1ps
module twi_ee_frontend #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [SYNC_STAGES-1:0] scl_sync_q, scl_sync_d;
  logic [SYNC_STAGES-1:0] sda_sync_q, sda_sync_d;
  logic                   scl_prev_q, sda_prev_q;

  // Synchronizer chain built stage by stage; idle bus level is high.
  always_comb begin
    scl_sync_d[0] = scl_i;
    sda_sync_d[0] = sda_i;
  end

  for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_sync
    always_comb begin
      scl_sync_d[g] = scl_sync_q[g-1];
      sda_sync_d[g] = sda_sync_q[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync_q <= '1;
      sda_sync_q <= '1;
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_sync_q <= scl_sync_d;
      sda_sync_q <= sda_sync_d;
      scl_prev_q <= scl_s;
      sda_prev_q <= sda_s;
    end
  end

  always_comb begin
    scl_s     = scl_sync_q[SYNC_STAGES-1];
    sda_s     = sda_sync_q[SYNC_STAGES-1];
    scl_rise  = scl_s & ~scl_prev_q;
    scl_fall  = ~scl_s & scl_prev_q;
    start_det = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
    stop_det  = scl_s & scl_prev_q & ~sda_prev_q & sda_s;
  end

endmodule

// File: rtl/twi_ee_mem.sv
`timescale 1ns/1ps
module twi_ee_mem #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_i,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem_q[wr_addr] <= wr_data;
    end
  end

  always_comb rd_data = mem_q[rd_addr];

  AST_WP_BLOCKS_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    wp_i |-> !wr_en); // R10

endmodule

// File: rtl/twi_ee_ctrl.sv
`timescale 1ns/1ps
module twi_ee_ctrl
  import twi_ee_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [2:0]        strap_i,
  input  logic              wp_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              wr_en_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              sda_oe_o
);

  localparam int                HI_W      = ADDR_W - DATA_W;
  localparam int                CNT_W     = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0]  BYTE_BITS = CNT_W'(DATA_W);

  ee_state_e         state_q, state_d;
  rx_kind_e          kind_q, kind_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              oe_q, oe_d;
  logic              rd_q, rd_d;
  logic              mack_q, mack_d;
  logic              load_tx;

  // Next-state logic
  always_comb begin
    state_d = state_q;
    kind_d  = kind_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    addr_d  = addr_q;
    oe_d    = oe_q;
    rd_d    = rd_q;
    mack_d  = mack_q;
    wr_en_o = 1'b0;
    load_tx = 1'b0;

    if (stop_det) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
    end else if (start_det) begin
      state_d = ST_RX;
      kind_d  = K_DEV;
      cnt_d   = '0;
      oe_d    = 1'b0;
      rd_d    = 1'b0;
    end else begin
      unique case (state_q)
        ST_RX: begin
          if (scl_rise && (cnt_q != BYTE_BITS)) begin
            sh_d  = {sh_q[DATA_W-2:0], sda_s};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && (cnt_q == BYTE_BITS)) begin
            cnt_d   = '0;
            state_d = ST_RX_ACK;
            oe_d    = 1'b1;
            case (kind_q)
              K_DEV: begin
                if (!slave_match(sh_q, strap_i)) begin
                  state_d = ST_IDLE;
                  oe_d    = 1'b0;
                end else if (sh_q[0]) begin
                  rd_d = 1'b1;
                end else begin
                  addr_d[ADDR_W-1:DATA_W] = sh_q[HI_W:1];
                  kind_d                  = K_ADDR;
                end
              end
              K_ADDR: begin
                addr_d[DATA_W-1:0] = sh_q;
                kind_d             = K_DATA;
              end
              default: begin
                wr_en_o = ~wp_i;
                addr_d  = addr_q + 1'b1;
              end
            endcase
          end
        end
        ST_RX_ACK: begin
          if (scl_fall) begin
            if (rd_q) begin
              load_tx = 1'b1;
            end else begin
              oe_d    = 1'b0;
              state_d = ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt_q == BYTE_BITS) begin
              oe_d    = 1'b0;
              state_d = ST_TX_ACK;
            end else begin
              sh_d  = {sh_q[DATA_W-2:0], 1'b0};
              oe_d  = ~sh_q[DATA_W-2];
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) begin
            mack_d = ~sda_s;
          end
          if (scl_fall) begin
            if (mack_q) begin
              load_tx = 1'b1;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        default: begin
        end
      endcase

      if (load_tx) begin
        sh_d    = rd_data_i;
        addr_d  = addr_q + 1'b1;
        oe_d    = ~rd_data_i[DATA_W-1];
        cnt_d   = CNT_W'(1);
        state_d = ST_TX;
      end
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      kind_q  <= K_DEV;
      cnt_q   <= '0;
      sh_q    <= '0;
      addr_q  <= '0;
      oe_q    <= 1'b0;
      rd_q    <= 1'b0;
      mack_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      kind_q  <= kind_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      addr_q  <= addr_d;
      oe_q    <= oe_d;
      rd_q    <= rd_d;
      mack_q  <= mack_d;
    end
  end

  always_comb begin
    mem_addr_o = addr_q;
    wr_data_o  = sh_q;
    sda_oe_o   = oe_q;
  end

  AST_OE_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(oe_q) |-> !scl_s); // R3
  AST_START_REDECODE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det && !stop_det) |=> (state_q == ST_RX) && (kind_q == K_DEV) && (cnt_q == '0)); // R2
  AST_STOP_GOES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (state_q == ST_IDLE) && !oe_q); // R2
  AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !oe_q); // R4
  AST_STORE_STEPS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |=> addr_q == $past(addr_q) + 1'b1); // R7
  AST_ACK_ONLY_NINTH: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RX) |-> !oe_q); // R5

endmodule

// File: rtl/twi_eeprom_slave.sv
`timescale 1ns/1ps
module twi_eeprom_slave #(
  parameter int ADDR_W      = 11,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic [2:0] strap_i,
  input  logic       wp_i
);

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [ADDR_W-1:0] mem_addr;
  logic              wr_en;
  logic [DATA_W-1:0] wr_data, rd_data;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  always_comb rst_int_n = rst_sync_q[1];

  twi_ee_frontend #(
    .SYNC_STAGES (SYNC_STAGES)
  ) u_front (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  twi_ee_ctrl #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .scl_s      (scl_s),
    .sda_s      (sda_s),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .strap_i    (strap_i),
    .wp_i       (wp_i),
    .rd_data_i  (rd_data),
    .mem_addr_o (mem_addr),
    .wr_en_o    (wr_en),
    .wr_data_o  (wr_data),
    .sda_oe_o   (sda_oe_o)
  );

  twi_ee_mem #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_mem (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wp_i    (wp_i),
    .wr_en   (wr_en),
    .wr_addr (mem_addr),
    .wr_data (wr_data),
    .rd_addr (mem_addr),
    .rd_data (rd_data)
  );

endmodule

// File: tb/twi_eeprom_slave_tb.sv
`timescale 1ns/1ps
module twi_eeprom_slave_tb;

  localparam int H     = 8;
  localparam int DEPTH = 2048;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic [2:0] strap = 3'b110;
  logic       wp = 1'b0;
  logic       sda_oe;
  logic       sda_bus;

  int n_checks = 0;
  int n_fail   = 0;

  logic [7:0] ref_mem [DEPTH];
  bit         known   [DEPTH];
  int         ref_addr = 0;
  logic [7:0] wbuf [8];

  always #2.5 clk = ~clk;

  assign sda_bus = sda_m & ~sda_oe;

  twi_eeprom_slave u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl),
    .sda_i    (sda_bus),
    .sda_oe_o (sda_oe),
    .strap_i  (strap),
    .wp_i     (wp)
  );

  // R3 monitor: output may only move while SCL is low.
  logic prev_oe = 1'b0;
  int   r3_bad = 0;
  int   oe_moves = 0;
  always @(negedge clk) begin
    if (rst_n && (sda_oe !== prev_oe)) begin
      oe_moves++;
      if (scl) r3_bad++;
    end
    prev_oe = sda_oe;
  end

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] dev_byte(input logic [2:0] hi, input logic rw);
    return {1'b1, strap[2], ~strap[1], strap[0], hi, rw};
  endfunction

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; hold(H);
    scl = 1'b1;   hold(H);
    sda_m = 1'b0; hold(H);
    scl = 1'b0;   hold(H);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; hold(H);
    scl = 1'b1;   hold(H);
    sda_m = 1'b1; hold(H);
  endtask

  task automatic tx_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hold(H);
      scl = 1'b1;   hold(H);
      scl = 1'b0;
    end
    sda_m = 1'b1; hold(H);
    scl = 1'b1;   hold(H);
    acked = ~sda_bus;
    scl = 1'b0;   hold(H);
  endtask

  task automatic rx_byte(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hold(H);
      scl = 1'b1; hold(H);
      b[i] = sda_bus;
      scl = 1'b0;
    end
    sda_m = ~mack; hold(H);
    scl = 1'b1;    hold(H);
    scl = 1'b0;    hold(H);
    sda_m = 1'b1;
  endtask

  task automatic do_write(input int addr, input int n);
    logic a;
    bus_start;
    tx_byte(dev_byte(3'(addr >> 8), 1'b0), a);
    check(a, "R5", {31'd0, a}, 32'd1);
    tx_byte(addr[7:0], a);
    check(a, "R5", {31'd0, a}, 32'd1);
    for (int k = 0; k < n; k++) begin
      tx_byte(wbuf[k], a);
      check(a, wp ? "R10" : "R5", {31'd0, a}, 32'd1);
      if (!wp) begin
        ref_mem[(addr + k) % DEPTH] = wbuf[k];
        known[(addr + k) % DEPTH]   = 1'b1;
      end
    end
    bus_stop;
    ref_addr = (addr + n) % DEPTH;
  endtask

  task automatic read_body(input int n, input string tag);
    logic [7:0] b;
    for (int k = 0; k < n; k++) begin
      rx_byte(k != n - 1, b);
      if (known[ref_addr]) check(b === ref_mem[ref_addr], tag, {24'd0, b}, {24'd0, ref_mem[ref_addr]});
      ref_addr = (ref_addr + 1) % DEPTH;
    end
    check(sda_oe == 1'b0, "R8", {31'd0, sda_oe}, 32'd0);
    bus_stop;
  endtask

  task automatic do_read_at(input int addr, input int n, input string tag);
    logic a;
    bus_start;
    tx_byte(dev_byte(3'(addr >> 8), 1'b0), a);
    tx_byte(addr[7:0], a);
    bus_start;
    tx_byte(dev_byte(3'b000, 1'b1), a);
    check(a, "R2", {31'd0, a}, 32'd1);
    ref_addr = addr % DEPTH;
    read_body(n, tag);
  endtask

  task automatic do_read_cur(input int n);
    logic a;
    bus_start;
    tx_byte(dev_byte(3'b101, 1'b1), a);
    check(a, "R5", {31'd0, a}, 32'd1);
    read_body(n, "R9");
  endtask

  initial begin
    logic a;
    int   addr, n;
    void'($urandom(32'd4242));
    for (int i = 0; i < DEPTH; i++) known[i] = 1'b0;

    hold(6);
    check(sda_oe == 1'b0, "R1", {31'd0, sda_oe}, 32'd0);
    rst_n = 1'b1;
    hold(6);
    check(sda_oe == 1'b0, "R1", {31'd0, sda_oe}, 32'd0);

    // Bytes with no START after reset.
    scl = 1'b0; hold(H);
    tx_byte(dev_byte(3'b000, 1'b0), a);
    check(!a, "R1", {31'd0, a}, 32'd0);
    bus_stop;

    // STOP returns to idle; following bytes without START are ignored.
    bus_start;
    tx_byte(dev_byte(3'b000, 1'b0), a);
    check(a, "R5", {31'd0, a}, 32'd1);
    bus_stop;
    scl = 1'b0; hold(H);
    tx_byte(dev_byte(3'b000, 1'b0), a);
    check(!a, "R2", {31'd0, a}, 32'd0);
    bus_stop;

    // Select decode: A1 must be inverted; MSB must be one.
    bus_start;
    tx_byte({1'b1, strap, 3'b000, 1'b0}, a);
    check(!a, "R4", {31'd0, a}, 32'd0);
    tx_byte(8'h00, a);
    check(!a, "R4", {31'd0, a}, 32'd0);
    bus_stop;
    bus_start;
    tx_byte({1'b0, strap[2], ~strap[1], strap[0], 3'b000, 1'b0}, a);
    check(!a, "R4", {31'd0, a}, 32'd0);
    bus_stop;

    // Wrap at the top of the array.
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    do_write(2046, 3);
    do_read_at(2046, 3, "R7");
    do_read_cur(1);

    // Write protect.
    wbuf[0] = 8'h5A;
    do_write(12'h123, 1);
    wp = 1'b1;
    wbuf[0] = 8'hA5;
    do_write(12'h123, 1);
    wp = 1'b0;
    do_read_at(12'h123, 1, "R10");

    // Random rounds.
    for (int it = 0; it < 24; it++) begin
      addr = int'($urandom % DEPTH);
      n    = 1 + int'($urandom % 4);
      for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
      wp = (($urandom % 4) == 0);
      do_write(addr, n);
      wp = 1'b0;
      do_read_at(addr, n, "R6 R8");
      if (it % 4 == 0) do_read_cur(2);
    end

    check(r3_bad == 0, "R3", r3_bad, 32'd0);
    check(oe_moves > 0, "R3", oe_moves, 32'd1);

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule